// File: doc/BRIEF.md
# Scalar FP64 Range-Restriction Unit

This unit takes two IEEE-754 double-precision operands and an 8-bit control byte, and returns one 128-bit result lane one clock after the operands are presented. It builds the result in two steps. The first step picks one operand with a selectable comparison: minimum, maximum, smaller magnitude or larger magnitude. The second step rewrites the sign bit of the picked value according to a separate control field. Signed zeros, ties of equal magnitude and NaN inputs each follow fixed rules, so the outcome never depends on how the comparison happens to be implemented.

The lower 64 bits of the lane hold the range result. A per-lane write mask can replace them with zero or with the previous destination value. The upper 64 bits always pass through from the first source. Three flags come with every result: invalid (a NaN was seen), denormal (a subnormal operand was seen), and a control error for reserved control bits that are not zero.

A common use is clamping. With control 8'h02 and a second operand of 1023.0, any value whose magnitude is below 1023 passes through unchanged. Anything larger saturates to 1023 and keeps its own sign.

Top module: `fp_range_unit`

## Requirements
- R1: Control bits [1:0] select the comparison: 2'b00 minimum, 2'b01 maximum, 2'b10 smaller magnitude, 2'b11 larger magnitude. When the two operands are bit-identical, the first source is returned.
- R2: Control bits [3:2] set the sign of the result: 2'b00 uses the sign of the first source, 2'b01 keeps the sign of the picked value, 2'b10 clears the sign, 2'b11 sets the sign.
- R3: For two zeros of opposite sign, minimum returns -0 and maximum returns +0. Smaller magnitude and larger magnitude both return the first source.
- R4: For nonzero operands of equal magnitude and opposite sign, smaller magnitude returns the negative operand and larger magnitude returns the positive operand.
- R5: If either operand is a NaN (exponent all ones, mantissa nonzero), the invalid flag is set. The result is then the first NaN operand, with its own sign and with mantissa bit 51 forced to 1, whatever the sign field says.
- R6: The denormal flag is set when either operand has a zero exponent and a nonzero mantissa.
- R7: The control-error flag equals the OR of control bits [7:4]. Those bits do not change the result.
- R8: The lane is active when mask_en is 0 or mask_bit is 1. On an inactive lane, result[63:0] becomes 0 if zero_mode is 1, and dest_old otherwise. The invalid and denormal flags read 0 for an inactive lane.
- R9: result[127:64] always equals src_a[127:64] from the accepted operation.
- R10: Latency is one cycle. out_valid is high exactly in the cycle after in_valid. The result and flags hold their values while in_valid is low. Reset clears all outputs to 0.
- R11: With control 8'h02 and src_b = 1023.0, an input of magnitude below 1023 is returned unchanged. A larger input returns 1023.0 with the input's sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| ctrl | input | 8 | Control byte: [1:0] compare, [3:2] sign, [7:4] reserved |
| src_a | input | 128 | First source lane; low 64 bits are the operand |
| src_b | input | 64 | Second source operand |
| dest_old | input | 64 | Previous destination low bits, used for merging |
| mask_en | input | 1 | 1 = write masking applies |
| mask_bit | input | 1 | Mask bit for the lane |
| zero_mode | input | 1 | 1 = zero an inactive lane, 0 = merge |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result lane |
| invalid_flag | output | 1 | NaN operand seen on an active lane |
| denorm_flag | output | 1 | Subnormal operand seen on an active lane |
| ctrl_err | output | 1 | Reserved control bits not zero |

## Verification
Every path from the inputs to the result passes through a single register stage. A wrong pick, a wrong sign rule or a wrong mask decision therefore shows up on the result port in the cycle right after in_valid. The fault does not carry into later operations, so each failure points to one stimulus vector. Problems with the register hold or enable show up instead as out_valid, or held result bits, that disagree with the previous cycle's in_valid. The random operand mix pairs each value with zeros, its own negation, infinities, subnormals and NaNs. This way the tie, signed-zero and NaN-priority branches are reached as often as the ordinary compare paths.

// File: rtl/fpr_pkg.sv
// Package: shared encodings for the FP64 range-restriction unit.
// Assumes IEEE-754 binary64 layout: sign, 11-bit exponent, 52-bit mantissa.
package fpr_pkg;

    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = FP_W - EXP_W - 1;
    localparam int LANE_W = 2 * FP_W;

    // Comparison selected by control bits [1:0]
    typedef enum logic [1:0] {
        CMP_MIN    = 2'b00,
        CMP_MAX    = 2'b01,
        CMP_MINMAG = 2'b10,
        CMP_MAXMAG = 2'b11
    } cmp_op_e;

    // Sign rule selected by control bits [3:2]
    typedef enum logic [1:0] {
        SGN_SRC_A  = 2'b00,
        SGN_PICKED = 2'b01,
        SGN_CLEAR  = 2'b10,
        SGN_SET    = 2'b11
    } sign_op_e;

    // Operand class bits produced by the classifier
    typedef struct packed {
        logic is_nan;
        logic is_zero;
        logic is_denorm;
    } fp_class_t;

endpackage

// File: rtl/fpr_classify.sv
// Module: fpr_classify
// Classifies one floating-point operand as NaN, zero or subnormal.
// Assumes operand width = 1 + EXP_W + MAN_W; purely combinational.
module fpr_classify
    import fpr_pkg::*;
#(
    parameter int EXP_BITS = EXP_W,
    parameter int MAN_BITS = MAN_W,
    localparam int OP_BITS = 1 + EXP_BITS + MAN_BITS
) (
    input  logic [OP_BITS-1:0] operand,
    output fp_class_t          cls
);

    logic [EXP_BITS-1:0] exp_f;
    logic [MAN_BITS-1:0] man_f;
    logic                exp_max;
    logic                exp_min;
    logic                man_nz;

    // Split fields and derive class flags
    always_comb begin
        exp_f         = operand[OP_BITS-2 -: EXP_BITS];
        man_f         = operand[MAN_BITS-1:0];
        exp_max       = &exp_f;
        exp_min       = ~|exp_f;
        man_nz        = |man_f;
        cls.is_nan    = exp_max & man_nz;
        cls.is_zero   = exp_min & ~man_nz;
        cls.is_denorm = exp_min & man_nz;
    end

endmodule

// File: rtl/fpr_select.sv
// Module: fpr_select
// Chooses one of two non-NaN operands for min, max, min-magnitude or
// max-magnitude. Opposite-signed zeros and equal-magnitude opposite-sign
// pairs resolve by fixed rules; identical operands return operand A.
// Assumes NaNs are handled downstream; infinities compare by magnitude.
module fpr_select
    import fpr_pkg::*;
#(
    parameter int OP_BITS = FP_W
) (
    input  logic [OP_BITS-1:0] op_a,
    input  logic [OP_BITS-1:0] op_b,
    input  cmp_op_e            cmp_op,
    input  logic               both_zero,
    output logic               pick_b,
    output logic [OP_BITS-1:0] picked
);

    localparam int MAG_BITS = OP_BITS - 1;

    logic [MAG_BITS-1:0] mag_a;
    logic [MAG_BITS-1:0] mag_b;
    logic                sgn_a;
    logic                sgn_b;
    logic                a_smaller;
    logic                b_smaller;
    logic                sgn_diff;

    // Magnitude and sign comparisons shared by all four operations
    always_comb begin
        mag_a     = op_a[MAG_BITS-1:0];
        mag_b     = op_b[MAG_BITS-1:0];
        sgn_a     = op_a[OP_BITS-1];
        sgn_b     = op_b[OP_BITS-1];
        a_smaller = mag_a < mag_b;
        b_smaller = mag_b < mag_a;
        sgn_diff  = sgn_a ^ sgn_b;
    end

    // Decide which operand the selected comparison returns
    always_comb begin
        pick_b = 1'b0;
        unique case (cmp_op)
            CMP_MIN: begin
                if (sgn_diff)      pick_b = sgn_b;
                else if (!sgn_a)   pick_b = b_smaller;
                else               pick_b = a_smaller;
            end
            CMP_MAX: begin
                if (sgn_diff)      pick_b = ~sgn_b;
                else if (!sgn_a)   pick_b = a_smaller;
                else               pick_b = b_smaller;
            end
            CMP_MINMAG: begin
                if (b_smaller)     pick_b = 1'b1;
                else if (a_smaller) pick_b = 1'b0;
                else if (sgn_diff && !both_zero) pick_b = sgn_b;
                else               pick_b = 1'b0;
            end
            CMP_MAXMAG: begin
                if (a_smaller)     pick_b = 1'b1;
                else if (b_smaller) pick_b = 1'b0;
                else if (sgn_diff && !both_zero) pick_b = ~sgn_b;
                else               pick_b = 1'b0;
            end
            default:               pick_b = 1'b0;
        endcase
    end

    // Route the chosen operand
    always_comb begin
        picked = pick_b ? op_b : op_a;
    end

endmodule

// File: rtl/fpr_finish.sv
// Module: fpr_finish
// Applies the sign rule to the picked value, or substitutes the quieted
// first NaN operand when a NaN is present (sign rule ignored then).
// Assumes the quiet bit is the top mantissa bit.
module fpr_finish
    import fpr_pkg::*;
#(
    parameter int OP_BITS  = FP_W,
    parameter int MAN_BITS = MAN_W
) (
    input  logic [OP_BITS-1:0] op_a,
    input  logic [OP_BITS-1:0] op_b,
    input  logic [OP_BITS-1:0] picked,
    input  sign_op_e           sign_op,
    input  logic               a_nan,
    input  logic               b_nan,
    output logic [OP_BITS-1:0] value,
    output logic               nan_seen
);

    localparam int QUIET_BIT = MAN_BITS - 1;
    localparam int SIGN_BIT  = OP_BITS - 1;

    logic                new_sign;
    logic [OP_BITS-1:0]  nan_val;
    logic [OP_BITS-1:0]  signed_val;

    // Compute the overriding sign bit
    always_comb begin
        unique case (sign_op)
            SGN_SRC_A:  new_sign = op_a[SIGN_BIT];
            SGN_PICKED: new_sign = picked[SIGN_BIT];
            SGN_CLEAR:  new_sign = 1'b0;
            SGN_SET:    new_sign = 1'b1;
            default:    new_sign = picked[SIGN_BIT];
        endcase
        signed_val = {new_sign, picked[SIGN_BIT-1:0]};
    end

    // Quiet the first NaN operand, A taking priority over B
    always_comb begin
        nan_val            = a_nan ? op_a : op_b;
        nan_val[QUIET_BIT] = 1'b1;
        nan_seen           = a_nan | b_nan;
        value              = nan_seen ? nan_val : signed_val;
    end

endmodule

// File: rtl/fp_range_unit.sv
// Module: fp_range_unit (top)
// One-lane FP64 range-restriction unit with write masking and a single
// registered output stage. Upper lane bits pass through from src_a.
// Assumes synchronous active-low reset; outputs hold between operations.
module fp_range_unit
    import fpr_pkg::*;
#(
    parameter int ELEM_W = FP_W,
    parameter int EXP_BW = EXP_W,
    localparam int MAN_BW = ELEM_W - EXP_BW - 1,
    localparam int LANE_BW = 2 * ELEM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         ctrl,
    input  logic [LANE_BW-1:0] src_a,
    input  logic [ELEM_W-1:0]  src_b,
    input  logic [ELEM_W-1:0]  dest_old,
    input  logic               mask_en,
    input  logic               mask_bit,
    input  logic               zero_mode,
    output logic               out_valid,
    output logic [LANE_BW-1:0] result,
    output logic               invalid_flag,
    output logic               denorm_flag,
    output logic               ctrl_err
);

    logic [ELEM_W-1:0] ops [2];
    fp_class_t         cls [2];
    logic              pick_b;
    logic [ELEM_W-1:0] picked;
    logic [ELEM_W-1:0] range_val;
    logic              nan_seen;
    logic              lane_on;
    logic [ELEM_W-1:0] low_next;
    cmp_op_e           cmp_op;
    sign_op_e          sign_op;

    // Gather operands and decode control fields
    always_comb begin
        ops[0]  = src_a[ELEM_W-1:0];
        ops[1]  = src_b;
        cmp_op  = cmp_op_e'(ctrl[1:0]);
        sign_op = sign_op_e'(ctrl[3:2]);
    end

    // One classifier per operand
    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        fpr_classify #(.EXP_BITS(EXP_BW), .MAN_BITS(MAN_BW)) cls_i (
            .operand (ops[gi]),
            .cls     (cls[gi])
        );
    end

    fpr_select #(.OP_BITS(ELEM_W)) sel_i (
        .op_a      (ops[0]),
        .op_b      (ops[1]),
        .cmp_op    (cmp_op),
        .both_zero (cls[0].is_zero & cls[1].is_zero),
        .pick_b    (pick_b),
        .picked    (picked)
    );

    fpr_finish #(.OP_BITS(ELEM_W), .MAN_BITS(MAN_BW)) fin_i (
        .op_a     (ops[0]),
        .op_b     (ops[1]),
        .picked   (picked),
        .sign_op  (sign_op),
        .a_nan    (cls[0].is_nan),
        .b_nan    (cls[1].is_nan),
        .value    (range_val),
        .nan_seen (nan_seen)
    );

    // Apply the write mask to the low element
    always_comb begin
        lane_on = ~mask_en | mask_bit;
        if (lane_on)        low_next = range_val;
        else if (zero_mode) low_next = '0;
        else                low_next = dest_old;
    end

    // Output register stage, updated only on accepted operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            invalid_flag <= 1'b0;
            denorm_flag  <= 1'b0;
            ctrl_err     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= {src_a[LANE_BW-1:ELEM_W], low_next};
                invalid_flag <= lane_on & nan_seen;
                denorm_flag  <= lane_on & (cls[0].is_denorm | cls[1].is_denorm);
                ctrl_err     <= |ctrl[7:4];
            end
        end
    end

endmodule

// File: rtl/fpr_checker.sv
// Module: fpr_checker
// Temporal checks on the ports of fp_range_unit; bound to every instance.
// Assumes the one-cycle latency and hold behaviour of the top module.
module fpr_checker #(
    parameter int ELEM_W = 64,
    localparam int LANE_BW = 2 * ELEM_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [7:0]         ctrl,
    input logic [LANE_BW-1:0] src_a,
    input logic [ELEM_W-1:0]  dest_old,
    input logic               mask_en,
    input logic               mask_bit,
    input logic               zero_mode,
    input logic               out_valid,
    input logic [LANE_BW-1:0] result,
    input logic               invalid_flag,
    input logic               ctrl_err
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result)); // R10
    AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result[LANE_BW-1:ELEM_W] == $past(src_a[LANE_BW-1:ELEM_W])); // R9
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_en && !mask_bit && zero_mode |=> result[ELEM_W-1:0] == '0 && !invalid_flag); // R8
    AST_MERGE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_en && !mask_bit && !zero_mode |=> result[ELEM_W-1:0] == $past(dest_old)); // R8
    AST_RSVD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ctrl_err == $past(|ctrl[7:4])); // R7
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && invalid_flag |-> (&result[ELEM_W-2:ELEM_W-12]) && result[ELEM_W-13]); // R5
    AST_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (!mask_en || mask_bit) && ctrl[3:2] == 2'b10 |=> invalid_flag || !result[ELEM_W-1]); // R2

endmodule

bind fp_range_unit fpr_checker #(.ELEM_W(ELEM_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .ctrl         (ctrl),
    .src_a        (src_a),
    .dest_old     (dest_old),
    .mask_en      (mask_en),
    .mask_bit     (mask_bit),
    .zero_mode    (zero_mode),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_flag (invalid_flag),
    .ctrl_err     (ctrl_err)
);

// File: tb/fp_range_unit_tb_top.sv
// Bench: directed corner cases plus seeded random operands, checked
// against a reference model built on real-number comparison.
module fp_range_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [7:0]   ctrl;
    logic [127:0] src_a;
    logic [63:0]  src_b;
    logic [63:0]  dest_old;
    logic         mask_en;
    logic         mask_bit;
    logic         zero_mode;
    logic         out_valid;
    logic [127:0] result;
    logic         invalid_flag;
    logic         denorm_flag;
    logic         ctrl_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk; // 250 MHz

    fp_range_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
        .src_a(src_a), .src_b(src_b), .dest_old(dest_old),
        .mask_en(mask_en), .mask_bit(mask_bit), .zero_mode(zero_mode),
        .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag),
        .denorm_flag(denorm_flag), .ctrl_err(ctrl_err)
    );

    function automatic bit is_nan(input logic [63:0] v);
        return v[62:52] == 11'h7ff && v[51:0] != 0;
    endfunction

    function automatic bit is_sub(input logic [63:0] v);
        return v[62:52] == 0 && v[51:0] != 0;
    endfunction

    // Reference model: {ctrl_err, invalid, denorm, low64}
    function automatic logic [66:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [7:0] c, input logic [63:0] old,
                                          input bit men, input bit mb, input bit zm);
        logic [63:0] v;
        bit inv, den, act;
        real ra, rb, fa, fb;
        act = !men || mb;
        inv = is_nan(a) || is_nan(b);
        den = is_sub(a) || is_sub(b);
        if (is_nan(a))      begin v = a; v[51] = 1'b1; end
        else if (is_nan(b)) begin v = b; v[51] = 1'b1; end
        else begin
            ra = $bitstoreal(a); rb = $bitstoreal(b);
            fa = ra < 0.0 ? -ra : ra; fb = rb < 0.0 ? -rb : rb;
            case (c[1:0])
                2'b00: v = (ra < rb) ? a : (rb < ra) ? b : (a[63] != b[63]) ? (a[63] ? a : b) : a;
                2'b01: v = (ra > rb) ? a : (rb > ra) ? b : (a[63] != b[63]) ? (a[63] ? b : a) : a;
                2'b10: v = (fa < fb) ? a : (fb < fa) ? b :
                           (fa != 0.0 && a[63] != b[63]) ? (a[63] ? a : b) : a;
                default: v = (fa > fb) ? a : (fb > fa) ? b :
                           (fa != 0.0 && a[63] != b[63]) ? (a[63] ? b : a) : a;
            endcase
            case (c[3:2])
                2'b00: v[63] = a[63];
                2'b01: ;
                2'b10: v[63] = 1'b0;
                default: v[63] = 1'b1;
            endcase
        end
        if (!act) begin
            v = zm ? 64'd0 : old;
            inv = 0; den = 0;
        end
        return {|c[7:4], inv, den, v};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, sample at the next falling edge
    task automatic run_op(input string tag, input logic [63:0] up, input logic [63:0] a,
                          input logic [63:0] b, input logic [7:0] c, input logic [63:0] old,
                          input bit men, input bit mb, input bit zm);
        logic [66:0] e;
        e = model(a, b, c, old, men, mb, zm);
        in_valid = 1; ctrl = c; src_a = {up, a}; src_b = b; dest_old = old;
        mask_en = men; mask_bit = mb; zero_mode = zm;
        @(negedge clk);
        in_valid = 0;
        check(tag, {64'd0, result[63:0]}, {64'd0, e[63:0]});
        check("R9 upper", {64'd0, result[127:64]}, {64'd0, up});
        check("R5 invalid", {127'd0, invalid_flag}, {127'd0, e[65]});
        check("R6 denorm", {127'd0, denorm_flag}, {127'd0, e[64]});
        check("R7 ctrl_err", {127'd0, ctrl_err}, {127'd0, e[66]});
        check("R10 out_valid", {127'd0, out_valid}, 128'd1);
    endtask

    function automatic logic [63:0] rand_op(input logic [63:0] other);
        logic [63:0] v;
        int k;
        k = $urandom_range(0, 9);
        case (k)
            0, 1, 2, 3: v = {$urandom_range(0,1) == 1, 11'(1013 + $urandom_range(0, 20)),
                             20'($urandom), $urandom};
            4: v = {$urandom_range(0,1) == 1, 63'd0};
            5: v = {$urandom_range(0,1) == 1, 11'd0, 20'($urandom), $urandom | 32'd1};
            6: v = {$urandom_range(0,1) == 1, 11'h7ff, 20'($urandom), $urandom | 32'd1};
            7: v = {$urandom_range(0,1) == 1, 11'h7ff, 52'd0};
            8: v = {~other[63], other[62:0]};
            default: v = other;
        endcase
        return v;
    endfunction

    function automatic logic [63:0] neg(input real r);
        return $realtobits(-r);
    endfunction

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] k1023, ra, rb, hold;
        void'($urandom(32'h5eed));
        k1023 = $realtobits(1023.0);
        rst_n = 0; in_valid = 0; ctrl = 0; src_a = 0; src_b = 0; dest_old = 0;
        mask_en = 0; mask_bit = 0; zero_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        check("R10 reset", {out_valid, invalid_flag, denorm_flag, ctrl_err, result[123:0]}, 128'd0);

        // R11 clamp to +/-1023 keeping the input sign
        run_op("R11 clamp high", 64'h1, $realtobits(2000.0), k1023, 8'h02, 0, 0, 0, 0);
        check("R11 explicit", {64'd0, result[63:0]}, {64'd0, k1023});
        run_op("R11 clamp low", 64'h2, neg(2000.0), k1023, 8'h02, 0, 0, 0, 0);
        check("R11 explicit", {64'd0, result[63:0]}, {64'd0, neg(1023.0)});
        run_op("R11 pass", 64'h3, neg(5.5), k1023, 8'h02, 0, 0, 0, 0);
        check("R11 explicit", {64'd0, result[63:0]}, {64'd0, neg(5.5)});

        // R3 opposite-signed zeros
        run_op("R3 min zeros", 0, 64'h0, 64'h8000_0000_0000_0000, 8'h04, 0, 0, 0, 0);
        check("R3 explicit", {64'd0, result[63:0]}, {64'd0, 64'h8000_0000_0000_0000});
        run_op("R3 max zeros", 0, 64'h8000_0000_0000_0000, 64'h0, 8'h05, 0, 0, 0, 0);
        check("R3 explicit", {64'd0, result[63:0]}, 128'd0);
        run_op("R3 minmag zeros", 0, 64'h8000_0000_0000_0000, 64'h0, 8'h06, 0, 0, 0, 0);
        check("R3 explicit", {64'd0, result[63:0]}, {64'd0, 64'h8000_0000_0000_0000});

        // R4 equal magnitude, opposite sign
        run_op("R4 minmag", 0, $realtobits(3.0), neg(3.0), 8'h06, 0, 0, 0, 0);
        check("R4 explicit", {64'd0, result[63:0]}, {64'd0, neg(3.0)});
        run_op("R4 maxmag", 0, neg(3.0), $realtobits(3.0), 8'h07, 0, 0, 0, 0);
        check("R4 explicit", {64'd0, result[63:0]}, {64'd0, $realtobits(3.0)});

        // R1 / R2 compare and sign rules
        run_op("R1 max", 0, $realtobits(3.0), neg(5.0), 8'h05, 0, 0, 0, 0);
        check("R1 explicit", {64'd0, result[63:0]}, {64'd0, $realtobits(3.0)});
        run_op("R2 set sign", 0, $realtobits(3.0), neg(5.0), 8'h0D, 0, 0, 0, 0);
        check("R2 explicit", {64'd0, result[63:0]}, {64'd0, neg(3.0)});
        run_op("R2 clear sign", 0, $realtobits(3.0), neg(5.0), 8'h08, 0, 0, 0, 0);
        check("R2 explicit", {64'd0, result[63:0]}, {64'd0, $realtobits(5.0)});

        // R5 NaN priority and quieting
        run_op("R5 nan a", 0, 64'h7FF0_0000_0000_0001, $realtobits(1.0), 8'h0C, 0, 0, 0, 0);
        check("R5 explicit", {64'd0, result[63:0]}, {64'd0, 64'h7FF8_0000_0000_0001});
        run_op("R5 nan b", 0, $realtobits(1.0), 64'hFFF0_0000_0000_0002, 8'h08, 0, 0, 0, 0);
        check("R5 explicit", {64'd0, result[63:0]}, {64'd0, 64'hFFF8_0000_0000_0002});

        // R6 subnormal, R7 reserved bits
        run_op("R6 denorm", 0, 64'h0000_0000_0000_0005, $realtobits(1.0), 8'h00, 0, 0, 0, 0);
        run_op("R7 reserved", 0, $realtobits(2.0), $realtobits(7.0), 8'h31, 0, 0, 0, 0);
        check("R7 explicit", {64'd0, result[63:0]}, {64'd0, $realtobits(7.0)});

        // R8 masking, including a NaN on an inactive lane
        run_op("R8 merge", 0, 64'h7FF0_0000_0000_0001, $realtobits(1.0), 8'h00, 64'hDEAD_BEEF_0123_4567, 1, 0, 0);
        run_op("R8 zero", 0, $realtobits(9.0), $realtobits(1.0), 8'h00, 64'hDEAD_BEEF_0123_4567, 1, 0, 1);
        run_op("R8 active", 0, $realtobits(9.0), $realtobits(1.0), 8'h01, 64'hDEAD_BEEF_0123_4567, 1, 1, 1);

        // R10 hold while idle
        hold = result[63:0];
        @(negedge clk);
        check("R10 idle valid", {127'd0, out_valid}, 128'd0);
        check("R10 idle hold", {64'd0, result[63:0]}, {64'd0, hold});

        // Random mix across all requirements (R1..R9 via the model)
        for (int i = 0; i < 3000; i++) begin
            ra = rand_op($urandom_range(0,1) == 1 ? k1023 : {$urandom, $urandom});
            rb = rand_op(ra);
            if ($urandom_range(0, 3) == 0) begin
                logic [63:0] t;
                t = ra; ra = rb; rb = t;
            end
            run_op("R1 random", {$urandom, $urandom}, ra, rb,
                   8'($urandom_range(0, 15)) | ($urandom_range(0, 7) == 0 ? 8'h40 : 8'h00),
                   {$urandom, $urandom}, $urandom_range(0,1) == 1,
                   $urandom_range(0,2) != 0, $urandom_range(0,1) == 1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule